// File: doc/BRIEF.md
# Debug Link Initialization Sequencer

This block brings a two-wire serial debug link from an unknown condition to a state where it can carry normal register traffic. When asked to start, it drives the data line itself through a fixed bring-up pattern. First comes a long stretch of high cycles that returns the target's port logic to its reset condition. Then comes a 16-bit code that switches the port from the scan-chain protocol to the two-wire protocol. A second stretch of high cycles follows, then a few low idle cycles. After that it hands control of the line to a separate transaction engine. Through the engine's command port it asks for a read of the identification register.

The engine returns the three-bit acknowledge and the 32-bit data word. A good acknowledge with the expected identification value declares the link up. A good acknowledge with any other value raises an identification-mismatch flag and halts the sequencer. A silent target, or any acknowledge other than OK, counts as a failed attempt and replays the whole sequence from the first line reset. After a parameterized number of failed attempts the sequencer stops and raises a failure flag. A restart request works in any state. While the link is up, a report from the engine that the target left the line undriven also restarts the sequence.

Top module: `dbg_link_init`

## Requirements
- R1: After reset every status output is low, the data line is not driven (`line_oe_o` low) and no command is offered, until `restart_i` is pulsed.
- R2: One cycle after `restart_i` is sampled high, the block drives the line high for exactly `RESET_CYCLES` consecutive cycles, and `RESET_CYCLES` must be at least 50.
- R3: Right after the first line reset, the block drives the 16-bit switch code `SWITCH_CODE` (default 0xE79E), one bit per cycle, least significant bit first.
- R4: After the switch code the line is held high for another `RESET_CYCLES` cycles, then driven low for `IDLE_CYCLES` cycles, and only then is the command offered.
- R5: The command is a debug-port read of register address 0 (`cmd_ap_o`=0, `cmd_rnw_o`=1, `cmd_addr_o`=00). `cmd_valid_o` stays high until `cmd_ready_i` is sampled high, and the block does not drive the line while the command is offered.
- R6: When the acknowledge code is OK (3'b001), the target drove the line, and the data equals `EXPECTED_ID`, `link_up_o` goes high in the following cycle.
- R7: When the acknowledge is OK but the data differs from `EXPECTED_ID`, `id_mismatch_o` goes high, `link_up_o` stays low, and the block stays there without driving the line or offering a command.
- R8: When the target does not drive the line, or the acknowledge is WAIT (3'b010), FAULT (3'b100) or any code other than OK, the whole sequence from R2 to R5 is replayed.
- R9: The `MAX_TRIES`-th consecutive failed attempt raises `init_fail_o`. The flag stays set, with the line undriven and no command offered, until a restart.
- R10: `restart_i` in any state, including partway through a line reset, clears every status flag and the attempt count and begins the sequence afresh from R2.
- R11: While the link is up, a response flagged as an undriven line drops `link_up_o` and restarts the sequence with a fresh attempt count.
- R12: While the link is up, a response whose line was driven has no effect: `link_up_o` stays high and the line remains undriven.
- R13: At most one of `link_up_o`, `id_mismatch_o` and `init_fail_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle during the driven phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Starts or restarts the bring-up sequence |
| line_oe_o | output | 1 | High while the sequencer drives the data line |
| line_dout_o | output | 1 | Data line value while driven |
| cmd_valid_o | output | 1 | Identification read command offered to the transaction engine |
| cmd_ready_i | input | 1 | Engine accepts the command |
| cmd_ap_o | output | 1 | Port select of the command, 0 = debug port |
| cmd_rnw_o | output | 1 | 1 = read command |
| cmd_addr_o | output | 2 | Register address bits of the command |
| rsp_valid_i | input | 1 | Engine response strobe |
| rsp_ack_i | input | 3 | Acknowledge code of the response |
| rsp_noresp_i | input | 1 | Target left the line undriven |
| rsp_data_i | input | ID_W | Read data of the response |
| link_up_o | output | 1 | Link is usable |
| id_mismatch_o | output | 1 | Identification value differs from the expected one |
| init_fail_o | output | 1 | Attempt limit reached |

## Verification
The assertions assume that the transaction engine pulses `rsp_valid_i` at most once for each accepted command, and only after that command. They also assume `restart_i` is a single-cycle request, so the checks on the first driven cycle and on a sticky failure see one clean edge. The bench plays the engine itself: it raises `cmd_ready_i` only while a command is offered, strobes a single response one cycle after accepting it, and sends the one stray response aimed at R12 only while the link is up. Restart pulses are one cycle wide, including the one placed in the middle of a line reset.

// File: rtl/dbg_link_init_pkg.sv
package dbg_link_init_pkg;

   // Acknowledge codes as delivered by the transaction engine.
   localparam logic [2:0] ACK_OK    = 3'b001;
   localparam logic [2:0] ACK_WAIT  = 3'b010;
   localparam logic [2:0] ACK_FAULT = 3'b100;

   // Register address of the identification register on the debug port.
   localparam logic [1:0] ID_REG_ADDR = 2'b00;

   // Minimum number of high cycles the line reset needs.
   localparam int MIN_LINE_RESET = 50;

   typedef enum logic [3:0] {
      ST_HOLD    = 4'd0,   // waiting for the first restart request
      ST_LRST_A  = 4'd1,   // first line reset
      ST_SWITCH  = 4'd2,   // protocol switch code
      ST_LRST_B  = 4'd3,   // second line reset
      ST_IDLE    = 4'd4,   // low idle cycles before the command
      ST_REQ     = 4'd5,   // identification read offered
      ST_WAIT    = 4'd6,   // waiting for the engine response
      ST_UP      = 4'd7,   // link usable
      ST_MISM    = 4'd8,   // wrong identification value
      ST_FAIL    = 4'd9    // attempt limit reached
   } link_st_e;

endpackage

// File: rtl/dbg_phase_timer.sv
module dbg_phase_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] len_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == len_i - CNT_W'(1));

endmodule

// File: rtl/dbg_line_pattern.sv
module dbg_line_pattern
   import dbg_link_init_pkg::*;
#(
   parameter int                     SWITCH_BITS      = 16,
   parameter logic [SWITCH_BITS-1:0] SWITCH_CODE      = 16'hE79E,
   parameter bit                     SWITCH_LSB_FIRST = 1'b1,
   parameter int                     CNT_W            = 6
) (
   input  link_st_e         st_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             oe_o,
   output logic             dout_o
);

   logic [SWITCH_BITS-1:0] shifted;
   logic                   sw_bit;

   generate
      if (SWITCH_LSB_FIRST) begin : g_lsb_first
         assign shifted = SWITCH_CODE >> cnt_i;
         assign sw_bit  = shifted[0];
      end else begin : g_msb_first
         assign shifted = SWITCH_CODE << cnt_i;
         assign sw_bit  = shifted[SWITCH_BITS-1];
      end
   endgenerate

   always_comb begin
      oe_o   = 1'b0;
      dout_o = 1'b0;
      case (st_i)
         ST_LRST_A, ST_LRST_B: begin
            oe_o   = 1'b1;
            dout_o = 1'b1;
         end
         ST_SWITCH: begin
            oe_o   = 1'b1;
            dout_o = sw_bit;
         end
         ST_IDLE: begin
            oe_o   = 1'b1;
            dout_o = 1'b0;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dbg_try_counter.sv
module dbg_try_counter #(
   parameter int MAX_TRIES = 3,
   parameter int TRY_W     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic final_o
);

   generate
      if (MAX_TRIES == 0) begin : g_unlimited
         // Zero selects endless retries: no failure is ever the final one.
         assign final_o = 1'b0;
      end else begin : g_limited
         logic [TRY_W-1:0] tries_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     tries_q <= '0;
            else if (clr_i) tries_q <= '0;
            else if (inc_i) tries_q <= tries_q + TRY_W'(1);
         end

         // High when the failure now being reported would reach the limit.
         assign final_o = (tries_q == TRY_W'(MAX_TRIES - 1));
      end
   endgenerate

endmodule

// File: rtl/dbg_link_init.sv
module dbg_link_init
   import dbg_link_init_pkg::*;
#(
   parameter int                     RESET_CYCLES     = 56,
   parameter int                     SWITCH_BITS      = 16,
   parameter logic [SWITCH_BITS-1:0] SWITCH_CODE      = 16'hE79E,
   parameter bit                     SWITCH_LSB_FIRST = 1'b1,
   parameter int                     IDLE_CYCLES      = 4,
   parameter int                     ID_W             = 32,
   parameter logic [ID_W-1:0]        EXPECTED_ID      = 32'h2BA01477,
   parameter int                     MAX_TRIES        = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart_i,
   output logic            line_oe_o,
   output logic            line_dout_o,
   output logic            cmd_valid_o,
   input  logic            cmd_ready_i,
   output logic            cmd_ap_o,
   output logic            cmd_rnw_o,
   output logic [1:0]      cmd_addr_o,
   input  logic            rsp_valid_i,
   input  logic [2:0]      rsp_ack_i,
   input  logic            rsp_noresp_i,
   input  logic [ID_W-1:0] rsp_data_i,
   output logic            link_up_o,
   output logic            id_mismatch_o,
   output logic            init_fail_o
);

   localparam int LONG_RS = (RESET_CYCLES > SWITCH_BITS) ? RESET_CYCLES : SWITCH_BITS;
   localparam int LONGEST = (LONG_RS > IDLE_CYCLES) ? LONG_RS : IDLE_CYCLES;
   localparam int CNT_W   = $clog2(LONGEST + 1);
   localparam int TRY_W   = $clog2(MAX_TRIES + 2);

   generate
      if (RESET_CYCLES < MIN_LINE_RESET) begin : g_bad_reset_len
         $error("RESET_CYCLES below the line reset minimum");
      end
      if (SWITCH_BITS < 1) begin : g_bad_switch_len
         $error("SWITCH_BITS must be positive");
      end
      if (IDLE_CYCLES < 1) begin : g_bad_idle_len
         $error("IDLE_CYCLES must be at least one");
      end
      if (MAX_TRIES < 0) begin : g_bad_tries
         $error("MAX_TRIES must not be negative");
      end
   endgenerate

   link_st_e         st_q, st_n;
   logic [CNT_W-1:0] ph_len, ph_cnt;
   logic             ph_last, ph_clr;
   logic             try_clr, try_inc, try_final;
   logic             rsp_bad, id_match;

   // Length of the timed phase the sequencer currently sits in.
   always_comb begin
      ph_len = CNT_W'(1);
      case (st_q)
         ST_LRST_A, ST_LRST_B: ph_len = CNT_W'(RESET_CYCLES);
         ST_SWITCH:            ph_len = CNT_W'(SWITCH_BITS);
         ST_IDLE:              ph_len = CNT_W'(IDLE_CYCLES);
         default:              ph_len = CNT_W'(1);
      endcase
   end

   assign rsp_bad  = rsp_noresp_i || (rsp_ack_i != ACK_OK);
   assign id_match = (rsp_data_i == EXPECTED_ID);

   always_comb begin
      st_n    = st_q;
      try_inc = 1'b0;
      try_clr = 1'b0;
      if (restart_i) begin
         st_n    = ST_LRST_A;
         try_clr = 1'b1;
      end else begin
         case (st_q)
            ST_LRST_A: if (ph_last) st_n = ST_SWITCH;
            ST_SWITCH: if (ph_last) st_n = ST_LRST_B;
            ST_LRST_B: if (ph_last) st_n = ST_IDLE;
            ST_IDLE:   if (ph_last) st_n = ST_REQ;
            ST_REQ:    if (cmd_ready_i) st_n = ST_WAIT;
            ST_WAIT: begin
               if (rsp_valid_i) begin
                  if (rsp_bad) begin
                     try_inc = 1'b1;
                     st_n    = try_final ? ST_FAIL : ST_LRST_A;
                  end else begin
                     st_n = id_match ? ST_UP : ST_MISM;
                  end
               end
            end
            ST_UP: begin
               if (rsp_valid_i && rsp_noresp_i) begin
                  st_n    = ST_LRST_A;
                  try_clr = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // A restart while already in the first reset must still rewind the timer.
   assign ph_clr = (st_n != st_q) || restart_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_HOLD;
      else        st_q <= st_n;
   end

   dbg_phase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (ph_clr),
      .len_i  (ph_len),
      .cnt_o  (ph_cnt),
      .last_o (ph_last)
   );

   dbg_line_pattern #(
      .SWITCH_BITS      (SWITCH_BITS),
      .SWITCH_CODE      (SWITCH_CODE),
      .SWITCH_LSB_FIRST (SWITCH_LSB_FIRST),
      .CNT_W            (CNT_W)
   ) u_pattern (
      .st_i   (st_q),
      .cnt_i  (ph_cnt),
      .oe_o   (line_oe_o),
      .dout_o (line_dout_o)
   );

   dbg_try_counter #(
      .MAX_TRIES (MAX_TRIES),
      .TRY_W     (TRY_W)
   ) u_tries (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (try_clr),
      .inc_i   (try_inc),
      .final_o (try_final)
   );

   assign cmd_valid_o   = (st_q == ST_REQ);
   assign cmd_ap_o      = 1'b0;
   assign cmd_rnw_o     = 1'b1;
   assign cmd_addr_o    = ID_REG_ADDR;
   assign link_up_o     = (st_q == ST_UP);
   assign id_mismatch_o = (st_q == ST_MISM);
   assign init_fail_o   = (st_q == ST_FAIL);

endmodule

// File: rtl/dbg_link_init_chk.sv
module dbg_link_init_chk
   import dbg_link_init_pkg::*;
#(
   parameter int              ID_W        = 32,
   parameter logic [ID_W-1:0] EXPECTED_ID = 32'h2BA01477
) (
   input logic            clk,
   input logic            rst_n,
   input logic            restart_i,
   input logic            line_oe_o,
   input logic            line_dout_o,
   input logic            cmd_valid_o,
   input logic            cmd_ready_i,
   input logic            cmd_ap_o,
   input logic            cmd_rnw_o,
   input logic [1:0]      cmd_addr_o,
   input logic            rsp_valid_i,
   input logic [2:0]      rsp_ack_i,
   input logic            rsp_noresp_i,
   input logic [ID_W-1:0] rsp_data_i,
   input logic            link_up_o,
   input logic            id_mismatch_o,
   input logic            init_fail_o
);

   assert_flags_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({link_up_o, id_mismatch_o, init_fail_o}));

   assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o && !cmd_ready_i && !restart_i |=> cmd_valid_o);

   assert_cmd_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> !cmd_ap_o && cmd_rnw_o && (cmd_addr_o == 2'b00) && !line_oe_o);

   assert_idle_before_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid_o) |-> $past(line_oe_o && !line_dout_o));

   assert_up_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_up_o) |-> $past(rsp_valid_i && !rsp_noresp_i && (rsp_ack_i == ACK_OK)
                                 && (rsp_data_i == EXPECTED_ID)));

   assert_mismatch_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_mismatch_o) |-> $past(rsp_valid_i && !rsp_noresp_i && (rsp_ack_i == ACK_OK)
                                     && (rsp_data_i != EXPECTED_ID)));

   assert_mismatch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      id_mismatch_o |-> !line_oe_o && !cmd_valid_o && !link_up_o);

   assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      init_fail_o && !restart_i |=> init_fail_o);

   assert_fail_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      init_fail_o |-> !line_oe_o && !cmd_valid_o);

   assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> line_oe_o && line_dout_o && !link_up_o && !id_mismatch_o && !init_fail_o);

   assert_drop_on_silence_R11: assert property (@(posedge clk) disable iff (!rst_n)
      link_up_o && rsp_valid_i && rsp_noresp_i && !restart_i |=>
         !link_up_o && line_oe_o && line_dout_o);

   assert_up_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
      link_up_o && rsp_valid_i && !rsp_noresp_i && !restart_i |=> link_up_o && !line_oe_o);

endmodule

bind dbg_link_init dbg_link_init_chk #(
   .ID_W        (ID_W),
   .EXPECTED_ID (EXPECTED_ID)
) u_dbg_link_init_chk (.*);

// File: tb/dbg_link_init_bench.sv
module dbg_link_init_bench;

   localparam int          RST_LEN  = 56;
   localparam int          SW_LEN   = 16;
   localparam logic [15:0] SW_CODE  = 16'hE79E;
   localparam int          IDLE_LEN = 4;
   localparam logic [31:0] GOOD_ID  = 32'h2BA01477;
   localparam int          TRIES    = 3;
   localparam int          TOTAL    = 2 * RST_LEN + SW_LEN + IDLE_LEN;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        restart_i = 1'b0;
   logic        cmd_ready_i = 1'b0;
   logic        rsp_valid_i = 1'b0;
   logic [2:0]  rsp_ack_i = 3'b000;
   logic        rsp_noresp_i = 1'b0;
   logic [31:0] rsp_data_i = '0;
   logic        line_oe_o, line_dout_o, cmd_valid_o, cmd_ap_o, cmd_rnw_o;
   logic [1:0]  cmd_addr_o;
   logic        link_up_o, id_mismatch_o, init_fail_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dbg_link_init #(
      .RESET_CYCLES     (RST_LEN),
      .SWITCH_BITS      (SW_LEN),
      .SWITCH_CODE      (SW_CODE),
      .SWITCH_LSB_FIRST (1'b1),
      .IDLE_CYCLES      (IDLE_LEN),
      .ID_W             (32),
      .EXPECTED_ID      (GOOD_ID),
      .MAX_TRIES        (TRIES)
   ) u_dbg_link_init (
      .clk           (clk),
      .rst_n         (rst_n),
      .restart_i     (restart_i),
      .line_oe_o     (line_oe_o),
      .line_dout_o   (line_dout_o),
      .cmd_valid_o   (cmd_valid_o),
      .cmd_ready_i   (cmd_ready_i),
      .cmd_ap_o      (cmd_ap_o),
      .cmd_rnw_o     (cmd_rnw_o),
      .cmd_addr_o    (cmd_addr_o),
      .rsp_valid_i   (rsp_valid_i),
      .rsp_ack_i     (rsp_ack_i),
      .rsp_noresp_i  (rsp_noresp_i),
      .rsp_data_i    (rsp_data_i),
      .link_up_o     (link_up_o),
      .id_mismatch_o (id_mismatch_o),
      .init_fail_o   (init_fail_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic exp_bit(input int idx);
      if (idx < RST_LEN)                 return 1'b1;
      if (idx < RST_LEN + SW_LEN)        return SW_CODE[idx - RST_LEN];
      if (idx < 2 * RST_LEN + SW_LEN)    return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [2:0] flags();
      return {link_up_o, id_mismatch_o, init_fail_o};
   endfunction

   task automatic pulse_restart();
      @(posedge clk); #1 restart_i = 1'b1;
      @(posedge clk); #1 restart_i = 1'b0;
   endtask

   // Records the driven line from the next negedge until the command shows.
   task automatic capture(input string tag);
      int  n = 0;
      int  bad_rst = 0;
      int  bad_sw = 0;
      int  bad_idle = 0;
      bit  gap = 1'b0;
      bit  flag_seen = 1'b0;
      bit  seen_cmd = 1'b0;
      for (int i = 0; i < 400 && !seen_cmd; i++) begin
         @(negedge clk);
         if (flags() != 3'b000) flag_seen = 1'b1;
         if (cmd_valid_o) seen_cmd = 1'b1;
         else if (!line_oe_o) gap = 1'b1;
         else begin
            if (line_dout_o !== exp_bit(n)) begin
               if (n < RST_LEN || (n >= RST_LEN + SW_LEN && n < 2 * RST_LEN + SW_LEN))
                  bad_rst++;
               else if (n < RST_LEN + SW_LEN) bad_sw++;
               else bad_idle++;
            end
            n++;
         end
      end
      chk(seen_cmd, "R5", {tag, " command offered"}, seen_cmd, 1);
      chk(n == TOTAL && !gap, "R2", {tag, " driven cycles before command"}, n, TOTAL);
      chk(bad_rst == 0, "R2", {tag, " line reset bits high"}, bad_rst, 0);
      chk(bad_sw == 0, "R3", {tag, " switch code bits"}, bad_sw, 0);
      chk(bad_idle == 0, "R4", {tag, " idle bits low"}, bad_idle, 0);
      chk(!flag_seen, "R10", {tag, " flags low during bring-up"}, flag_seen, 0);
      chk(!cmd_ap_o && cmd_rnw_o && cmd_addr_o == 2'b00 && !line_oe_o, "R5",
          {tag, " command fields {ap,rnw,addr,oe}"},
          {cmd_ap_o, cmd_rnw_o, cmd_addr_o, line_oe_o}, 5'b01000);
   endtask

   // Accepts the offered command, then returns one response.
   task automatic respond(input logic [2:0] ack, input logic noresp, input logic [31:0] data);
      cmd_ready_i = 1'b1;
      @(posedge clk); #1 cmd_ready_i = 1'b0;
      rsp_valid_i = 1'b1; rsp_ack_i = ack; rsp_noresp_i = noresp; rsp_data_i = data;
      @(posedge clk); #1 rsp_valid_i = 1'b0; rsp_noresp_i = 1'b0; rsp_ack_i = 3'b000;
   endtask

   task automatic t_reset_state();
      repeat (5) @(negedge clk);
      chk(flags() == 3'b000, "R1", "flags after reset", flags(), 0);
      chk(!line_oe_o, "R1", "line undriven after reset", line_oe_o, 0);
      chk(!cmd_valid_o, "R1", "no command after reset", cmd_valid_o, 0);
      // R13 is watched at every flag check below
   endtask

   task automatic t_good_bringup();
      pulse_restart();
      capture("good");
      repeat (3) begin
         @(negedge clk);
         chk(cmd_valid_o, "R5", "command held without ready", cmd_valid_o, 1);
      end
      respond(3'b001, 1'b0, GOOD_ID);
      @(negedge clk);
      chk(flags() == 3'b100, "R6", "link up after good id", flags(), 3'b100);
      chk(!line_oe_o, "R6", "line released when up", line_oe_o, 0);
   endtask

   task automatic t_up_ignores();
      @(posedge clk); #1 rsp_valid_i = 1'b1; rsp_ack_i = 3'b100; rsp_data_i = 32'h0;
      @(posedge clk); #1 rsp_valid_i = 1'b0; rsp_ack_i = 3'b000;
      @(negedge clk);
      chk(flags() == 3'b100, "R12", "link stays up on driven response", flags(), 3'b100);
      chk(!line_oe_o, "R12", "line stays undriven", line_oe_o, 0);
   endtask

   task automatic t_link_lost();
      @(posedge clk); #1 rsp_valid_i = 1'b1; rsp_noresp_i = 1'b1;
      @(posedge clk); #1 rsp_valid_i = 1'b0; rsp_noresp_i = 1'b0;
      capture("R11 relink");
      respond(3'b001, 1'b0, GOOD_ID);
      @(negedge clk);
      chk(flags() == 3'b100, "R11", "link up again after re-init", flags(), 3'b100);
   endtask

   task automatic t_mismatch();
      pulse_restart();
      capture("mismatch");
      respond(3'b001, 1'b0, GOOD_ID ^ 32'h0000_0100);
      @(negedge clk);
      chk(flags() == 3'b010, "R7", "mismatch flag", flags(), 3'b010);
      repeat (10) @(negedge clk);
      chk(flags() == 3'b010 && !line_oe_o && !cmd_valid_o, "R7",
          "mismatch holds quietly {flags,oe,cmd}",
          {flags(), line_oe_o, cmd_valid_o}, 5'b01000);
   endtask

   task automatic t_retry_then_fail();
      pulse_restart();
      capture("try1");
      respond(3'b000, 1'b1, 32'h0);
      capture("R8 after silence");
      respond(3'b010, 1'b0, GOOD_ID);
      capture("R8 after wait ack");
      respond(3'b100, 1'b0, GOOD_ID);
      @(negedge clk);
      chk(flags() == 3'b001, "R9", "fail flag after limit", flags(), 3'b001);
      repeat (20) @(negedge clk);
      chk(flags() == 3'b001 && !line_oe_o && !cmd_valid_o, "R9",
          "fail holds quietly {flags,oe,cmd}",
          {flags(), line_oe_o, cmd_valid_o}, 5'b00100);
   endtask

   task automatic t_restart();
      pulse_restart();
      repeat (30) @(negedge clk);
      pulse_restart();
      capture("R10 mid-reset restart");
      respond(3'b000, 1'b1, 32'h0);
      capture("R10 count cleared 2");
      respond(3'b100, 1'b0, 32'h0);
      capture("R10 count cleared 3");
      respond(3'b001, 1'b0, GOOD_ID);
      @(negedge clk);
      chk(flags() == 3'b100, "R10", "fresh attempt count after restart", flags(), 3'b100);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset_state();
      t_good_bringup();
      t_up_ignores();
      t_link_lost();
      t_mismatch();
      t_retry_then_fail();
      t_restart();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule